// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block divides a stream of oscillator strobes, nominally 32,768 per second, down to a single-cycle once-per-second tick. It corrects crystal error digitally: over a repeating cycle of 64 minutes, some minutes have their first second made shorter or longer. The calibration input is sign-magnitude. A magnitude of N selects how many minutes are affected, and the sign selects the direction.

The block also keeps a minute position (0 to 63) within that correction cycle. The calendar logic around it uses this position.

A separate 512 Hz square wave is available for frequency measurement. It is visible only when the test flag is set, the seconds byte is being read, and the oscillator is running. A stop flag freezes the whole chain.

The length of the chain is a parameter. `DIV_BITS` = 15 gives the 32,768-strobe second. The number of seconds per minute is also a parameter (default 60), so a bench can run a complete 64-minute correction cycle quickly.

Top module: `calsec_prescaler`

## Requirements
- R1: With no correction due, a second lasts exactly 2^DIV_BITS strobes of `osc_en`. `tick_1hz` is high during the cycle that consumes the last strobe of the second, and is low otherwise.
- R2: When `cal_mag` is 0, every second has the nominal length, whatever the value of `cal_pos`.
- R3: With `cal_pos` = 1, an affected second is 256 strobes shorter than nominal.
- R4: With `cal_pos` = 0, an affected second is 128 strobes longer than nominal.
- R5: Only second index 0 of a minute can be affected. It is affected only when the minute position is below 2×`cal_mag`, so minutes 62 and 63 are never corrected.
- R6: `minute_idx` advances by one on every SECS_PER_MIN-th tick and wraps from 63 to 0. It holds its value in all other cycles.
- R7: The calibration inputs are captured during reset and at each minute boundary. A change in the middle of a minute has no effect until the next minute begins.
- R8: `ftest_out` is a square wave that changes level every 32 strobes (512 Hz at the nominal rate) and is not affected by calibration. It is 0 unless `ftest` = 1, `sec_rd` = 1 and `stop` = 0.
- R9: While `stop` = 1, no tick occurs and the minute position does not change. After `stop` is cleared, the first tick ends a complete second measured from the release.
- R10: Only cycles with `osc_en` = 1 advance the divider. Gaps in the strobe stream stretch the second in clock cycles but not in strobes.
- R11: Reset is synchronous and active low. It leaves `tick_1hz` = 0, `minute_idx` = 0 and `ftest_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_en | input | 1 | One strobe per oscillator cycle |
| cal_mag | input | 5 | Calibration magnitude, 0 to 31 |
| cal_pos | input | 1 | Calibration sign: 1 speeds up, 0 slows down |
| stop | input | 1 | Halts and clears the divider |
| ftest | input | 1 | Enables the frequency-test output |
| sec_rd | input | 1 | High while the seconds byte is being read |
| tick_1hz | output | 1 | One-cycle pulse at the end of each second |
| minute_idx | output | 6 | Minute position in the 64-minute correction cycle |
| ftest_out | output | 1 | Gated 512 Hz test square wave |

## Verification
The hardest case to reach is the wrap of the correction cycle. It only appears after 64 minutes of ticks, and it is the only place where a large magnitude must leave minutes 62 and 63 untouched and then correct minute 0 again.

The bench shortens the chain to 512 strobes and uses two seconds per minute. With the largest positive magnitude, it times all 130 seconds of more than one full cycle against a model of the requirements.

A mid-minute calibration change is created by writing new calibration values right after the first tick of a minute. Stop is applied partway through a second, so the bench can check that the partial count is discarded.

// File: rtl/calsec_pkg.sv
// Shared definitions for the calibrated seconds prescaler.
// Assumes the correction cycle is always 64 minutes long and that
// corrections act at the 256-strobe stage of the divider chain.
package calsec_pkg;
    localparam int LO_BITS     = 8;    // width of the divide-by-256 stage
    localparam int MIN_PER_CYC = 64;   // minutes in one correction cycle
    localparam int MIN_W       = 6;
    localparam int FT_TAP      = 5;    // counter bit whose level changes every 32 strobes

    // Kind of adjustment applied to the second that is running now
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;
endpackage

// File: rtl/calsec_lo_stage.sv
// Divide-by-256 stage. Counts strobes and raises carry on the strobe that
// completes 256 of them. Assumes load_half is only asserted together with
// carry; it restarts the stage at 128 so that 128 extra strobes are inserted.
module calsec_lo_stage
    import calsec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               clr,
    input  logic               load_half,
    output logic               carry
);
    logic [LO_BITS-1:0] lo_q;

    assign carry = step && (lo_q == {LO_BITS{1'b1}});

    // Purpose: advance the 256-strobe count, or restart it at half for a long second
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lo_q <= '0;
        end else if (step) begin
            if (load_half) lo_q <= {1'b1, {(LO_BITS-1){1'b0}}};
            else           lo_q <= lo_q + 1'b1;
        end
    end
endmodule

// File: rtl/calsec_hi_stage.sv
// Upper stage of the seconds chain. Counts carries from the 256-stage.
// A short second ends one carry early. A long second asks the lower stage
// for one extra half pass before it ends. Assumes adj is stable for the
// whole second.
module calsec_hi_stage
    import calsec_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carry,
    input  logic clr,
    input  adj_e adj,
    output logic sec_end,
    output logic load_half
);
    localparam int HI_W = DIV_BITS - LO_BITS;
    localparam logic [HI_W-1:0] HI_LAST = {HI_W{1'b1}};

    logic [HI_W-1:0] hi_q;
    logic            ext_q;
    logic [HI_W-1:0] term;
    logic            at_term;

    // Purpose: choose the carry count that ends this second
    always_comb begin
        term    = (adj == ADJ_SHORT) ? HI_LAST - 1'b1 : HI_LAST;
        at_term = (hi_q == term);
    end

    assign sec_end   = carry && (ext_q || (at_term && adj != ADJ_LONG));
    assign load_half = carry && at_term && (adj == ADJ_LONG) && !ext_q;

    // Purpose: count carries and track the extension pass of a long second
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi_q  <= '0;
            ext_q <= 1'b0;
        end else if (carry) begin
            if (sec_end) begin
                hi_q  <= '0;
                ext_q <= 1'b0;
            end else if (load_half) begin
                ext_q <= 1'b1;
            end else begin
                hi_q  <= hi_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/calsec_cal_seq.sv
// Correction sequencer. Tracks the second within the minute and the minute
// within the 64-minute cycle. Captures the calibration inputs in reset and
// at each minute boundary, and decides the adjustment for the current second.
module calsec_cal_seq
    import calsec_pkg::*;
#(
    parameter int SECS_PER_MIN = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [4:0]       cal_mag,
    input  logic             cal_pos,
    output adj_e             adj,
    output logic [MIN_W-1:0] minute
);
    localparam int SIDX_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
    localparam logic [SIDX_W-1:0] SIDX_LAST = SIDX_W'(SECS_PER_MIN - 1);

    logic [SIDX_W-1:0] sidx_q;
    logic [4:0]        mag_q;
    logic              pos_q;

    // Purpose: step second and minute counters, and capture calibration per minute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sidx_q <= '0;
            minute <= '0;
            mag_q  <= cal_mag;
            pos_q  <= cal_pos;
        end else if (tick) begin
            if (sidx_q == SIDX_LAST) begin
                sidx_q <= '0;
                minute <= minute + 1'b1;
                mag_q  <= cal_mag;
                pos_q  <= cal_pos;
            end else begin
                sidx_q <= sidx_q + 1'b1;
            end
        end
    end

    // Purpose: correct the first second of each of the first 2N minutes
    always_comb begin
        adj = ADJ_NONE;
        if (sidx_q == '0 && minute < {mag_q, 1'b0})
            adj = pos_q ? ADJ_SHORT : ADJ_LONG;
    end
endmodule

// File: rtl/calsec_ftest.sv
// Frequency-test generator. Free-running strobe counter, independent of the
// correction path, whose tap bit changes level every 32 strobes. The output
// is gated by the test flag, the seconds-read qualifier and the running state.
module calsec_ftest
    import calsec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clr,
    input  logic ftest,
    input  logic sec_rd,
    output logic ftest_out
);
    logic [FT_TAP:0] cnt_q;

    // Purpose: count strobes for the test square wave
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (step)     cnt_q <= cnt_q + 1'b1;
    end

    assign ftest_out = ftest && sec_rd && !clr && cnt_q[FT_TAP];
endmodule

// File: rtl/calsec_prescaler.sv
// Calibrated seconds prescaler, top level. Chains the 256 stage and the upper
// stage into a seconds divider. The sequencer supplies the correction for each
// second, and a separate counter produces the frequency-test output.
// Assumes DIV_BITS >= 9, so a shortened second is still longer than zero.
module calsec_prescaler
    import calsec_pkg::*;
#(
    parameter int DIV_BITS     = 15,
    parameter int SECS_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic [4:0] cal_mag,
    input  logic       cal_pos,
    input  logic       stop,
    input  logic       ftest,
    input  logic       sec_rd,
    output logic       tick_1hz,
    output logic [5:0] minute_idx,
    output logic       ftest_out
);
    logic step;
    logic carry;
    logic load_half;
    adj_e adj;

    assign step = osc_en && !stop;

    calsec_lo_stage u_lo (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clr       (stop),
        .load_half (load_half),
        .carry     (carry)
    );

    calsec_hi_stage #(.DIV_BITS(DIV_BITS)) u_hi (
        .clk       (clk),
        .rst_n     (rst_n),
        .carry     (carry),
        .clr       (stop),
        .adj       (adj),
        .sec_end   (tick_1hz),
        .load_half (load_half)
    );

    calsec_cal_seq #(.SECS_PER_MIN(SECS_PER_MIN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .cal_mag (cal_mag),
        .cal_pos (cal_pos),
        .adj     (adj),
        .minute  (minute_idx)
    );

    calsec_ftest u_ft (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clr       (stop),
        .ftest     (ftest),
        .sec_rd    (sec_rd),
        .ftest_out (ftest_out)
    );
endmodule

// File: rtl/calsec_checker.sv
// Property checker for calsec_prescaler, attached by bind. It measures the
// length of each second with its own strobe counter, so the window is never
// unrolled from a parameter.
module calsec_checker #(
    parameter int DIV_BITS = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_en,
    input logic       stop,
    input logic       ftest,
    input logic       sec_rd,
    input logic       tick_1hz,
    input logic [5:0] minute_idx,
    input logic       ftest_out
);
    localparam int NOM = 1 << DIV_BITS;
    localparam logic [DIV_BITS:0] LEN_NOM   = (DIV_BITS+1)'(NOM - 1);
    localparam logic [DIV_BITS:0] LEN_SHORT = (DIV_BITS+1)'(NOM - 257);
    localparam logic [DIV_BITS:0] LEN_LONG  = (DIV_BITS+1)'(NOM + 127);

    logic [DIV_BITS:0] since_q;

    // Purpose: count strobes since the last tick or stop
    always_ff @(posedge clk) begin
        if (!rst_n || stop || tick_1hz) since_q <= '0;
        else if (osc_en)                since_q <= since_q + 1'b1;
    end

    // R1: a tick only consumes a real strobe
    p_tick_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> osc_en);

    // R3 / R4: every second has one of the three legal lengths
    p_len_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> (since_q == LEN_NOM || since_q == LEN_SHORT || since_q == LEN_LONG));

    // R5: the last two minutes of the cycle are never corrected
    p_late_nominal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && minute_idx >= 6'd62) |-> since_q == LEN_NOM);

    // R6: the minute position holds unless a tick occurs
    p_minute_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz |=> $stable(minute_idx));

    // R6: the minute position only ever steps by one, modulo 64
    p_minute_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |=> (minute_idx == $past(minute_idx) || minute_idx == $past(minute_idx) + 6'd1));

    // R8: the test output is gated by flag, read qualifier and running state
    p_ft_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ftest_out |-> (ftest && sec_rd && !stop));

    // R9: no tick while stopped
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> !tick_1hz);
endmodule

bind calsec_prescaler calsec_checker #(.DIV_BITS(DIV_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .stop       (stop),
    .ftest      (ftest),
    .sec_rd     (sec_rd),
    .tick_1hz   (tick_1hz),
    .minute_idx (minute_idx),
    .ftest_out  (ftest_out)
);

// File: tb/sim_calsec_prescaler.sv
module sim_calsec_prescaler;
    localparam int DIVB = 9;
    localparam int SPM  = 2;
    localparam int NOM  = 1 << DIVB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic [4:0] cal_mag = '0;
    logic       cal_pos = 1'b0;
    logic       stop = 1'b0;
    logic       ftest = 1'b0;
    logic       sec_rd = 1'b0;
    logic       tick_1hz;
    logic [5:0] minute_idx;
    logic       ftest_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    calsec_prescaler #(.DIV_BITS(DIVB), .SECS_PER_MIN(SPM)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_mag(cal_mag),
        .cal_pos(cal_pos), .stop(stop), .ftest(ftest), .sec_rd(sec_rd),
        .tick_1hz(tick_1hz), .minute_idx(minute_idx), .ftest_out(ftest_out)
    );

    typedef struct packed { logic [4:0] mag; logic pos; } vec_t;
    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{5'd0, 1'b1}, '{5'd0, 1'b0}, '{5'd1, 1'b1},
        '{5'd1, 1'b0}, '{5'd2, 1'b1}, '{5'd31, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Length of second s counted from reset, with calibration fixed
    function automatic int exp_len(input int s, input int mag, input bit pos);
        int m;
        m = (s / SPM) % 64;
        if ((s % SPM) == 0 && m < 2 * mag) return pos ? NOM - 256 : NOM + 128;
        return NOM;
    endfunction

    task automatic do_reset(input logic [4:0] mag, input logic pos);
        @(negedge clk);
        rst_n = 1'b0; cal_mag = mag; cal_pos = pos; osc_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Starts and ends just after a falling edge; counts strobes up to the tick
    task automatic run_sec(input bit gap, output int strobes, output int clocks);
        bit hit;
        strobes = 0; clocks = 0;
        forever begin
            if (gap) osc_en = ~osc_en;
            #1;
            clocks++;
            if (osc_en) strobes++;
            hit = tick_1hz;
            @(negedge clk);
            if (hit || clocks > 5000) break;
        end
        osc_en = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len, clks;
        int c [3];
        int nc;
        logic prev;
        bit quiet;
        logic [5:0] m0;

        // R11: reset state, with the test gate open
        ftest = 1'b1; sec_rd = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(tick_1hz == 1'b0, "R11 tick", tick_1hz, 0);
        check(minute_idx == 6'd0, "R11 minute", minute_idx, 0);
        check(ftest_out == 1'b0, "R11 ftest_out", ftest_out, 0);
        ftest = 1'b0; sec_rd = 1'b0;

        // Vector table: R1, R2, R3, R4, R5 over the first three minutes
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VECS[v].mag, VECS[v].pos);
            for (int s = 0; s < 6; s++) begin
                run_sec(1'b0, len, clks);
                check(len == exp_len(s, VECS[v].mag, VECS[v].pos),
                      (VECS[v].mag == 0) ? "R2 length" : (VECS[v].pos ? "R3 length" : "R4 length"),
                      len, exp_len(s, VECS[v].mag, VECS[v].pos));
            end
        end

        // R5 / R6: more than a full cycle at the largest positive magnitude
        do_reset(5'd31, 1'b1);
        for (int s = 0; s < 130; s++) begin
            run_sec(1'b0, len, clks);
            check(len == exp_len(s, 31, 1'b1), "R5 length", len, exp_len(s, 31, 1'b1));
            check(minute_idx == 6'(((s + 1) / SPM) % 64), "R6 minute", minute_idx, ((s + 1) / SPM) % 64);
        end

        // R7: a change in the middle of a minute waits for the next minute
        do_reset(5'd0, 1'b0);
        run_sec(1'b0, len, clks);
        check(len == NOM, "R7 first", len, NOM);
        cal_mag = 5'd1; cal_pos = 1'b1;
        run_sec(1'b0, len, clks);
        check(len == NOM, "R7 mid-minute", len, NOM);
        run_sec(1'b0, len, clks);
        check(len == NOM - 256, "R7 next minute", len, NOM - 256);

        // R10: gaps in the strobe stream
        do_reset(5'd0, 1'b0);
        run_sec(1'b1, len, clks);
        check(len == NOM, "R10 strobes", len, NOM);
        check(clks >= 2 * NOM - 1, "R10 clocks", clks, 2 * NOM - 1);

        // R9: stop partway through a second
        do_reset(5'd0, 1'b0);
        repeat (100) @(negedge clk);
        stop = 1'b1;
        quiet = 1'b1;
        #1 m0 = minute_idx;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #1;
            if (tick_1hz) quiet = 1'b0;
        end
        check(quiet, "R9 no tick", !quiet, 0);
        check(minute_idx == m0, "R9 minute", minute_idx, m0);
        @(negedge clk);
        stop = 1'b0;
        run_sec(1'b0, len, clks);
        check(len == NOM, "R9 restart", len, NOM);

        // R8: 512 Hz test output during a corrected second
        do_reset(5'd31, 1'b1);
        ftest = 1'b1; sec_rd = 1'b1;
        nc = 0;
        #1 prev = ftest_out;
        for (int i = 1; i < 200; i++) begin
            @(negedge clk); #1;
            if (ftest_out != prev && nc < 3) begin c[nc] = i; nc++; end
            prev = ftest_out;
        end
        check(nc == 3, "R8 edges", nc, 3);
        check(c[1] - c[0] == 32, "R8 half period", c[1] - c[0], 32);
        check(c[2] - c[1] == 32, "R8 half period", c[2] - c[1], 32);
        sec_rd = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); #1;
            if (ftest_out) quiet = 1'b0;
        end
        check(quiet, "R8 no read", !quiet, 0);
        sec_rd = 1'b1; ftest = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); #1;
            if (ftest_out) quiet = 1'b0;
        end
        check(quiet, "R8 flag off", !quiet, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule